// File: doc/BRIEF.md
# Stipple and Blit Engine for an 8-bit Pixel Store

This block is a write-only drawing accelerator for a frame buffer of one byte per pixel. A host issues 32-bit register writes into one of two windows. The stipple window paints a held colour into up to 32 neighbouring pixels, selected by a bit mask. The blit window either fills a run of pixels with the held colour or copies a run from a source pixel address to a destination pixel address.

Every operation takes two writes. The first write, with offset bit 2 clear, only loads the held word. The second write, with offset bit 2 set, starts the work. The offset of that second write carries the destination pixel address. The engine then works on a single-port synchronous pixel memory at one access per cycle, and it holds `busy` high until the last access is issued. The host polls `busy` before it issues the next trigger.

Top module: `paint_engine`

## Requirements
- R1: A write with offset bit 2 = 0 stores all 32 data bits as the held word. It starts nothing and changes no pixel.
- R2: A write with offset bit 2 = 1 starts an operation when the engine is idle. The destination pixel is bits 22:3 of the offset, which is the offset shifted right by 3 and kept to 20 bits.
- R3: Stipple (`bus_blit` = 0): data bit 31 selects the destination pixel, and each lower bit selects the next pixel to the right. Only pixels whose bit is 1 are written, and they take bits 7:0 of the held word.
- R4: Blit (`bus_blit` = 1): the run length is data bits 28:24 plus one, so a run covers 1 to 32 pixels.
- R5: Blit with data bits 23:0 = 0xFFFFFF is a fill. Every pixel of the run takes bits 7:0 of the held word.
- R6: Blit with any other value in bits 23:0 is a copy from that source pixel address, in ascending order. Each source pixel is read in the cycle before its destination is written, so an overlapping copy behaves like a forward byte copy.
- R7: Reads from either window return zero (`bus_rdata` = 0).
- R8: `busy` is high from the cycle after a trigger until the operation ends. A trigger that arrives while `busy` is high is ignored. Out of reset, `busy` is low and the memory port is quiet.
- R9: A stipple whose mask is all zero ends without any memory write.
- R10: The colour is captured when the trigger is accepted. A write to the held word while `busy` is high affects only later operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_blit | input | 1 | Window select: 0 = stipple, 1 = blit |
| bus_addr | input | 23 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | Pixel memory access enable |
| mem_we | output | 1 | Pixel memory write (1) or read (0) |
| mem_addr | output | 20 | Pixel address |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data, valid the cycle after a read |

## Verification
Two functions can fall in the same cycle: a host write to the held word or a new trigger, and a running operation that is using the captured colour and its own counters. The bench provokes this by sending a second trigger, and separately a new colour write, while a 32-pixel fill is still running. It then compares the whole pixel memory with a model in which only the first operation took place with the old colour. A later operation must show that the new colour was still latched.

// File: rtl/paint_pkg.sv
package paint_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_STIP  = 3'd1,
    SEQ_FILL  = 3'd2,
    SEQ_CRD   = 3'd3,
    SEQ_CWR   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/paint_rst_sync.sv
module paint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/paint_hold.sv
module paint_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_n;

  always_comb begin
    q_n = q;
    if (ld) q_n = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (ld) q <= q_n;
  end
endmodule

// File: rtl/paint_decode.sv
module paint_decode #(
  parameter int OFS_W  = 23,
  parameter int DW     = 32,
  parameter int SRC_W  = 24,
  parameter int PIX_AW = 20,
  parameter int LEN_W  = $clog2(DW) + 1
) (
  input  logic              wr,
  input  logic              sel_blit,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  output logic              ld,
  output logic              go,
  output logic              go_blit,
  output logic              go_fill,
  output logic [PIX_AW-1:0] go_dst,
  output logic [PIX_AW-1:0] go_src,
  output logic [LEN_W-1:0]  go_len,
  output logic [DW-1:0]     go_mask
);
  localparam int LF_W = $clog2(DW);
  localparam logic [SRC_W-1:0] FILL_CODE = '1;

  logic [SRC_W-1:0] src_field;
  logic [LF_W-1:0]  len_field;

  always_comb begin
    src_field = wdata[SRC_W-1:0];
    len_field = wdata[SRC_W +: LF_W];
    ld        = wr && !addr[2];
    go        = wr && addr[2] && !busy;
    go_blit   = sel_blit;
    go_fill   = (src_field == FILL_CODE);
    go_dst    = addr[3 +: PIX_AW];
    go_src    = src_field[PIX_AW-1:0];
    go_len    = {1'b0, len_field} + LEN_W'(1);
    go_mask   = wdata;
  end
endmodule

// File: rtl/paint_seq.sv
module paint_seq
  import paint_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PIX_W  = 8,
  parameter int PIX_AW = 20,
  parameter int LEN_W  = $clog2(DW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_blit,
  input  logic              go_fill,
  input  logic [PIX_AW-1:0] go_dst,
  input  logic [PIX_AW-1:0] go_src,
  input  logic [LEN_W-1:0]  go_len,
  input  logic [DW-1:0]     go_mask,
  input  logic [PIX_W-1:0]  colour,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata
);
  seq_state_e        st_q,   st_n;
  logic [PIX_AW-1:0] dst_q,  dst_n;
  logic [PIX_AW-1:0] src_q,  src_n;
  logic [DW-1:0]     mask_q, mask_n;
  logic [LEN_W-1:0]  cnt_q,  cnt_n;
  logic [PIX_W-1:0]  col_q,  col_n;
  logic [DW-1:0]     mask_sh;
  logic              last;
  logic              upd;

  always_comb begin
    st_n      = st_q;
    dst_n     = dst_q;
    src_n     = src_q;
    mask_n    = mask_q;
    cnt_n     = cnt_q;
    col_n     = col_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dst_q;
    mem_wdata = col_q;
    mask_sh   = {mask_q[DW-2:0], 1'b0};
    last      = (cnt_q == LEN_W'(1));
    unique case (st_q)
      SEQ_IDLE: begin
        if (go) begin
          dst_n  = go_dst;
          src_n  = go_src;
          mask_n = go_mask;
          cnt_n  = go_len;
          col_n  = colour;
          if (!go_blit)     st_n = SEQ_STIP;
          else if (go_fill) st_n = SEQ_FILL;
          else              st_n = SEQ_CRD;
        end
      end
      SEQ_STIP: begin
        if (mask_q == '0) begin
          st_n = SEQ_IDLE;
        end else begin
          mem_en = mask_q[DW-1];
          mem_we = mask_q[DW-1];
          mask_n = mask_sh;
          dst_n  = dst_q + PIX_AW'(1);
          if (mask_sh == '0) st_n = SEQ_IDLE;
        end
      end
      SEQ_FILL: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        dst_n  = dst_q + PIX_AW'(1);
        cnt_n  = cnt_q - LEN_W'(1);
        if (last) st_n = SEQ_IDLE;
      end
      SEQ_CRD: begin
        mem_en   = 1'b1;
        mem_addr = src_q;
        st_n     = SEQ_CWR;
      end
      SEQ_CWR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = mem_rdata;
        dst_n     = dst_q + PIX_AW'(1);
        src_n     = src_q + PIX_AW'(1);
        cnt_n     = cnt_q - LEN_W'(1);
        st_n      = last ? SEQ_IDLE : SEQ_CRD;
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  assign upd  = go || (st_q != SEQ_IDLE);
  assign busy = (st_q != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      dst_q  <= '0;
      src_q  <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
      col_q  <= '0;
    end else if (upd) begin
      st_q   <= st_n;
      dst_q  <= dst_n;
      src_q  <= src_n;
      mask_q <= mask_n;
      cnt_q  <= cnt_n;
      col_q  <= col_n;
    end
  end
endmodule

// File: rtl/paint_engine.sv
module paint_engine #(
  parameter int OFS_W  = 23,
  parameter int DW     = 32,
  parameter int SRC_W  = 24,
  parameter int PIX_W  = 8,
  parameter int PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_blit,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);
  localparam int LEN_W = $clog2(DW) + 1;

  logic              rst_sync_n;
  logic              ld, go, go_blit, go_fill;
  logic [PIX_AW-1:0] go_dst, go_src;
  logic [LEN_W-1:0]  go_len;
  logic [DW-1:0]     go_mask;
  logic [DW-1:0]     held;

  assign bus_rdata = '0;

  paint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  paint_decode #(
    .OFS_W (OFS_W), .DW (DW), .SRC_W (SRC_W), .PIX_AW (PIX_AW), .LEN_W (LEN_W)
  ) u_dec (
    .wr       (bus_wr),
    .sel_blit (bus_blit),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .busy     (busy),
    .ld       (ld),
    .go       (go),
    .go_blit  (go_blit),
    .go_fill  (go_fill),
    .go_dst   (go_dst),
    .go_src   (go_src),
    .go_len   (go_len),
    .go_mask  (go_mask)
  );

  paint_hold #(.DW (DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (ld),
    .d     (bus_wdata),
    .q     (held)
  );

  paint_seq #(
    .DW (DW), .PIX_W (PIX_W), .PIX_AW (PIX_AW), .LEN_W (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .go        (go),
    .go_blit   (go_blit),
    .go_fill   (go_fill),
    .go_dst    (go_dst),
    .go_src    (go_src),
    .go_len    (go_len),
    .go_mask   (go_mask),
    .colour    (held[PIX_W-1:0]),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );
endmodule

// File: rtl/paint_engine_chk.sv
module paint_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_wr,
  input logic trig,
  input logic busy,
  input logic mem_en,
  input logic mem_we
);
  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && trig && !busy |=> busy); // R2

  AST_HOLD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !trig && !busy |=> !busy); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R8

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !mem_we |=> mem_en && mem_we); // R6
endmodule

bind paint_engine paint_engine_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .bus_wr (bus_wr),
  .trig   (bus_addr[2]),
  .busy   (busy),
  .mem_en (mem_en),
  .mem_we (mem_we)
);

// File: tb/paint_engine_test.sv
module paint_engine_test;
  localparam int MSZ = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_blit = 1'b0;
  logic [22:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy, mem_en, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem  [MSZ];
  logic [7:0]  refm [MSZ];
  logic [31:0] pend = '0;
  int          n_chk = 0, n_bad = 0, wcount = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  paint_engine uut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_blit (bus_blit),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .busy (busy), .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wcount <= wcount + 1;
    end else if (mem_en) begin
      mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, fa = 0, fe = 0, fi = -1;
    for (int i = 0; i < MSZ; i++)
      if (mem[i] !== refm[i]) begin
        bad++;
        if (fi < 0) begin fi = i; fa = mem[i]; fe = refm[i]; end
      end
    if (bad != 0) $display("  first mismatch at pixel %0d", fi);
    check(bad == 0, req, fa, fe);
  endtask

  task automatic bus_write(input bit blit, input logic [22:0] ofs, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_blit = blit; bus_addr = ofs; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_colour(input logic [31:0] c);
    bus_write(1'b0, 23'h000010, c);
    pend = c;
  endtask

  task automatic ref_apply(input bit blit, input int dst, input logic [31:0] d, input logic [7:0] col);
    int len;
    if (!blit) begin
      for (int i = 0; i < 32; i++) if (d[31-i]) refm[dst+i] = col;
    end else begin
      len = int'(d[28:24]) + 1;
      for (int i = 0; i < len; i++)
        if (d[23:0] == 24'hFFFFFF) refm[dst+i] = col;
        else refm[dst+i] = refm[int'(d[11:0])+i];
    end
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic run_op(input bit blit, input int dst, input logic [31:0] d, input string req);
    logic [22:0] ofs;
    ofs = {dst[19:0], 3'b100};
    bus_write(blit, ofs, d);
    ref_apply(blit, dst, d, pend[7:0]);
    wait_idle();
    cmp_mem(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int w0, dst, src, kind, lf;
    logic [31:0] d;
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 8'($urandom);
      refm[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 R7: reset state
    check(busy == 1'b0, "R8 busy after reset", busy, 0);
    check(mem_en == 1'b0, "R8 memory quiet after reset", mem_en, 0);
    check(bus_rdata == 32'h0, "R7 read data zero", bus_rdata, 0);

    // R1: held-word write starts nothing
    w0 = wcount;
    set_colour(32'hDEAD_BE5A);
    @(negedge clk);
    check(busy == 1'b0, "R1 no busy after hold write", busy, 0);
    check(wcount == w0, "R1 no pixel writes", wcount - w0, 0);
    cmp_mem("R1 memory unchanged");

    // R3 R2: stipple edge bits
    run_op(1'b0, 100, 32'h8000_0001, "R3 stipple first and last bit");
    run_op(1'b0, 1000, 32'hA5F0_0F5A, "R3 stipple pattern");

    // R9: zero mask
    w0 = wcount;
    run_op(1'b0, 200, 32'h0, "R9 zero mask memory");
    check(wcount == w0, "R9 zero mask writes", wcount - w0, 0);

    // R4 R5: fill lengths
    set_colour(32'h0000_0033);
    w0 = wcount;
    run_op(1'b1, 300, 32'h1FFF_FFFF, "R5 fill 32");
    check(wcount - w0 == 32, "R4 run length 32", wcount - w0, 32);
    w0 = wcount;
    run_op(1'b1, 400, 32'h00FF_FFFF, "R5 fill 1");
    check(wcount - w0 == 1, "R4 run length 1", wcount - w0, 1);

    // R6: copy, overlapping both directions
    run_op(1'b1, 503, 32'h0900_01F4, "R6 forward overlap copy");
    run_op(1'b1, 600, 32'h1F00_0263, "R6 backward overlap copy");

    // R8 R10: trigger and colour write during a running fill
    set_colour(32'h0000_0077);
    bus_write(1'b1, {20'd700, 3'b100}, 32'h1FFF_FFFF);
    ref_apply(1'b1, 700, 32'h1FFF_FFFF, 8'h77);
    check(busy == 1'b1, "R8 busy during operation", busy, 1);
    bus_write(1'b0, {20'd800, 3'b100}, 32'hFFFF_FFFF);
    bus_write(1'b0, 23'h000000, 32'h0000_00C1);
    pend = 32'h0000_00C1;
    wait_idle();
    cmp_mem("R8 R10 trigger ignored, colour kept");
    run_op(1'b1, 900, 32'h03FF_FFFF, "R10 new colour used later");

    // random mix
    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(1, 0) == 1) set_colour($urandom);
      kind = $urandom_range(2, 0);
      dst  = $urandom_range(3900, 0);
      src  = $urandom_range(3900, 0);
      lf   = $urandom_range(31, 0);
      if (kind == 0)      d = $urandom;
      else if (kind == 1) d = {3'b000, 5'(lf), 24'hFFFFFF};
      else                d = {3'b000, 5'(lf), 12'h000, 12'(src)};
      if (kind == 0)      run_op(1'b0, dst, d, "R3 random stipple");
      else if (kind == 1) run_op(1'b1, dst, d, "R5 random fill");
      else                run_op(1'b1, dst, d, "R6 random copy");
    end
    check(bus_rdata == 32'h0, "R7 read data zero at end", bus_rdata, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule